// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor core that completes one instruction in every clock cycle. Each cycle it reads a 32-bit instruction from its own instruction memory at the program counter, decodes it, reads up to two of its 32 general registers and computes a result. In the same clock edge it writes the result to a register or to data memory and moves the program counter on. Instructions come in three fixed layouts: register, immediate and jump. The core supports integer add and subtract, the logic operations, set-on-less-than, constant shifts, word loads and stores, two conditional branches, two absolute jumps and a jump through a register.

Both memories are plain word arrays. Each has a write-only load port, so a program and its data can be placed while the core is held in reset. Every cycle the core presents the effects of the instruction it is executing on a set of trace outputs: the program counter, the instruction word, the register write and the data-memory store. An environment can follow execution through these outputs without looking inside the core.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low, `wb_en_o` and `st_en_o` stay low. After any clock edge with `rst_n` low, `pc_o` is 0 and every register reads 0.
- R2: With bits [31:26] = 0, bits [5:0] select the register operation, with operands rs [25:21] and rt [20:16] and the result written to rd [15:11]: 32/33 sum, 34/35 difference rs−rt, 36 AND, 37 OR, 39 NOR. Sums and differences wrap without any trap.
- R3: Function 0 shifts rt left and function 2 shifts rt right with zero fill. The distance is bits [10:6], and the result goes to rd.
- R4: Immediate operations write rt with rs combined with bits [15:0]. Opcodes 8 and 9 add the sign-extended immediate. Opcode 12 ANDs and opcode 13 ORs the zero-extended immediate.
- R5: Opcode 15 writes rt with the immediate in bits [31:16] and zeros in bits [15:0].
- R6: Function 42 and opcode 10 compare as signed values. Function 43 and opcode 11 compare as unsigned values, with the immediate sign-extended. The destination receives 1 if rs is less, else 0.
- R7: Opcode 35 loads and opcode 43 stores a word at byte address rs + sign-extended immediate. The word index is address bits [DAW+1:2]. A store writes the value of rt and writes no register.
- R8: Opcode 4 branches when rs equals rt, and opcode 5 when they differ. The target is the branch address + 4 + 4 × sign-extended immediate. When the branch is not taken, the PC advances by 4.
- R9: Opcode 2 jumps and opcode 3 jumps and links. The target is bits [31:28] of (PC + 4), then bits [25:0], then two zeros. Opcode 3 also writes PC + 4 to register 31.
- R10: Function 8 loads the PC from register rs, with the two low address bits forced to zero. It writes no register.
- R11: Register 0 always reads 0. An instruction whose destination is register 0 raises no `wb_en_o`.
- R12: Any opcode or function value not listed above writes nothing, stores nothing and advances the PC by 4.
- R13: A load-port write stores its word at the given index on the clock edge. The instruction word is fetched from index PC bits [IAW+1:2]. A data load-port write takes priority over a core store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_ld_en | input | 1 | Instruction memory load write enable |
| imem_ld_idx | input | IAW | Instruction memory word index for load |
| imem_ld_word | input | 32 | Instruction word to load |
| dmem_ld_en | input | 1 | Data memory load write enable |
| dmem_ld_idx | input | DAW | Data memory word index for load |
| dmem_ld_word | input | 32 | Data word to load |
| pc_o | output | 32 | Address of the executing instruction |
| instr_o | output | 32 | Executing instruction word |
| wb_en_o | output | 1 | Register write this cycle |
| wb_reg_o | output | 5 | Register written |
| wb_val_o | output | 32 | Value written |
| st_en_o | output | 1 | Data store this cycle |
| st_addr_o | output | 32 | Store byte address |
| st_val_o | output | 32 | Store data |

## Verification
A wrong program counter shows on `pc_o` and `instr_o` in the very next cycle. A wrong register or memory word stays hidden until a later instruction reads it. It then shows as a wrong `wb_val_o`, `st_addr_o` or `st_val_o`, or as a wrong branch direction one cycle later. That delay can be many cycles, so the random programs read and reuse registers and memory words heavily, and every cycle's trace is compared against an independent instruction-level model. Directed sequences pin the signed and unsigned comparisons, the extension rules, both branch senses, linking and the register-0 rule to known values.

// File: rtl/sc_pkg.sv
// Package: shared widths, instruction field codes and control types for the
// single-cycle core. Assumes a 32-bit word and 32 architectural registers.
package sc_pkg;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);

    // major opcodes
    localparam logic [5:0] OP_SPECIAL = 6'd0;
    localparam logic [5:0] OP_J       = 6'd2;
    localparam logic [5:0] OP_JAL     = 6'd3;
    localparam logic [5:0] OP_BEQ     = 6'd4;
    localparam logic [5:0] OP_BNE     = 6'd5;
    localparam logic [5:0] OP_ADDI    = 6'd8;
    localparam logic [5:0] OP_ADDIU   = 6'd9;
    localparam logic [5:0] OP_SLTI    = 6'd10;
    localparam logic [5:0] OP_SLTIU   = 6'd11;
    localparam logic [5:0] OP_ANDI    = 6'd12;
    localparam logic [5:0] OP_ORI     = 6'd13;
    localparam logic [5:0] OP_LUI     = 6'd15;
    localparam logic [5:0] OP_LW      = 6'd35;
    localparam logic [5:0] OP_SW      = 6'd43;

    // function codes under OP_SPECIAL
    localparam logic [5:0] FN_SLL  = 6'd0;
    localparam logic [5:0] FN_SRL  = 6'd2;
    localparam logic [5:0] FN_JR   = 6'd8;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_ADDU = 6'd33;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_SUBU = 6'd35;
    localparam logic [5:0] FN_AND  = 6'd36;
    localparam logic [5:0] FN_OR   = 6'd37;
    localparam logic [5:0] FN_NOR  = 6'd39;
    localparam logic [5:0] FN_SLT  = 6'd42;
    localparam logic [5:0] FN_SLTU = 6'd43;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
        ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_HI
    } alu_op_e;

    typedef enum logic [2:0] {
        NX_SEQ, NX_EQ, NX_NE, NX_ABS, NX_REG
    } nxt_e;

    typedef struct packed {
        alu_op_e          alu;
        logic             b_imm;   // second operand is the immediate
        logic             zext;    // immediate zero-extended
        logic             wr;      // instruction writes a register
        logic [RIDX-1:0]  dst;
        logic             ld;
        logic             st;
        logic             link;
        nxt_e             nxt;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
// Decoder: turns opcode/function fields into control. Assumes unlisted codes
// must behave as a no-op (no write, no store, sequential next address).
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0]      op_i,
    input  logic [5:0]      fn_i,
    input  logic [RIDX-1:0] rt_i,
    input  logic [RIDX-1:0] rd_i,
    output ctrl_t           ctl_o
);
    // Purpose: map each listed opcode/function to its control word.
    always_comb begin
        ctl_o       = '0;
        ctl_o.alu   = ALU_ADD;
        ctl_o.nxt   = NX_SEQ;
        unique case (op_i)
            OP_SPECIAL: begin
                ctl_o.dst = rd_i;
                ctl_o.wr  = 1'b1;
                case (fn_i)
                    FN_ADD, FN_ADDU: ctl_o.alu = ALU_ADD;
                    FN_SUB, FN_SUBU: ctl_o.alu = ALU_SUB;
                    FN_AND:          ctl_o.alu = ALU_AND;
                    FN_OR:           ctl_o.alu = ALU_OR;
                    FN_NOR:          ctl_o.alu = ALU_NOR;
                    FN_SLT:          ctl_o.alu = ALU_SLT;
                    FN_SLTU:         ctl_o.alu = ALU_SLTU;
                    FN_SLL:          ctl_o.alu = ALU_SLL;
                    FN_SRL:          ctl_o.alu = ALU_SRL;
                    FN_JR: begin
                        ctl_o.wr  = 1'b0;
                        ctl_o.nxt = NX_REG;
                    end
                    default:         ctl_o.wr  = 1'b0;
                endcase
            end
            OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU, OP_ANDI, OP_ORI, OP_LUI: begin
                ctl_o.dst   = rt_i;
                ctl_o.wr    = 1'b1;
                ctl_o.b_imm = 1'b1;
                ctl_o.zext  = (op_i == OP_ANDI) || (op_i == OP_ORI);
                case (op_i)
                    OP_SLTI:  ctl_o.alu = ALU_SLT;
                    OP_SLTIU: ctl_o.alu = ALU_SLTU;
                    OP_ANDI:  ctl_o.alu = ALU_AND;
                    OP_ORI:   ctl_o.alu = ALU_OR;
                    OP_LUI:   ctl_o.alu = ALU_HI;
                    default:  ctl_o.alu = ALU_ADD;
                endcase
            end
            OP_LW: begin
                ctl_o.dst   = rt_i;
                ctl_o.wr    = 1'b1;
                ctl_o.b_imm = 1'b1;
                ctl_o.ld    = 1'b1;
            end
            OP_SW: begin
                ctl_o.b_imm = 1'b1;
                ctl_o.st    = 1'b1;
            end
            OP_BEQ:  ctl_o.nxt = NX_EQ;
            OP_BNE:  ctl_o.nxt = NX_NE;
            OP_J:    ctl_o.nxt = NX_ABS;
            OP_JAL: begin
                ctl_o.nxt  = NX_ABS;
                ctl_o.wr   = 1'b1;
                ctl_o.link = 1'b1;
                ctl_o.dst  = RIDX'(NREG - 1);
            end
            default: ctl_o.nxt = NX_SEQ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
// ALU: combinational integer unit. Assumes no overflow detection is needed;
// shifts take their distance from a separate 5-bit field.
module sc_alu
    import sc_pkg::*;
(
    input  logic [XLEN-1:0]          a,
    input  logic [XLEN-1:0]          b,
    input  logic [$clog2(XLEN)-1:0]  shamt,
    input  alu_op_e                  op,
    output logic [XLEN-1:0]          y
);
    localparam int HALF = XLEN / 2;

    // Purpose: select the result of the requested operation.
    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_NOR:  y = ~(a | b);
            ALU_SLT:  y = XLEN'($signed(a) < $signed(b));
            ALU_SLTU: y = XLEN'(a < b);
            ALU_SLL:  y = b << shamt;
            ALU_SRL:  y = b >> shamt;
            ALU_HI:   y = {b[HALF-1:0], {HALF{1'b0}}};
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
// Register file: two combinational read ports, one synchronous write port.
// Assumes entry 0 is hard-wired to zero and all entries clear on reset.
module sc_regfile
    import sc_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = XLEN,
    localparam int AW = $clog2(N)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra_a,
    output logic [W-1:0]  rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_b
);
    logic [W-1:0] q [N];

    // Purpose: clear on reset, keep entry 0 at zero, else write the addressed entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n || i == 0) begin
                q[i] <= '0;
            end else if (we && wa == AW'(i)) begin
                q[i] <= wd;
            end
        end
    end

    assign rd_a = q[ra_a];
    assign rd_b = q[ra_b];
endmodule

// File: rtl/sc_wordmem.sv
// Word memory: one synchronous write port, one combinational read port.
// Assumes no reset of contents; the environment loads it before use.
module sc_wordmem #(
    parameter int WORDS = 256,
    parameter int W     = 32,
    localparam int AW   = $clog2(WORDS)
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ridx,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [WORDS];

    // Purpose: store one word on an enabled clock edge.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: fetch, decode, execute, memory and writeback in one
// clock. Assumes both memories are loaded through their load ports while
// rst_n is low; word-aligned fetch and data access (low address bits ignored).
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 512,
    parameter int DMEM_WORDS = 256,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            imem_ld_en,
    input  logic [IAW-1:0]  imem_ld_idx,
    input  logic [XLEN-1:0] imem_ld_word,
    input  logic            dmem_ld_en,
    input  logic [DAW-1:0]  dmem_ld_idx,
    input  logic [XLEN-1:0] dmem_ld_word,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] instr_o,
    output logic            wb_en_o,
    output logic [RIDX-1:0] wb_reg_o,
    output logic [XLEN-1:0] wb_val_o,
    output logic            st_en_o,
    output logic [XLEN-1:0] st_addr_o,
    output logic [XLEN-1:0] st_val_o
);
    localparam int IMMW = 16;

    logic [XLEN-1:0] pc_q, pc_nx, pc_inc;
    logic [XLEN-1:0] instr, rs_v, rt_v, imm_ext, alu_b, alu_y, ld_v;
    logic [XLEN-1:0] br_tgt, jmp_tgt, reg_tgt;
    logic            dm_we;
    logic [DAW-1:0]  dm_widx;
    logic [XLEN-1:0] dm_wdata;
    ctrl_t           ctl;

    // Purpose: program counter register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_nx;
        end
    end

    assign pc_inc = pc_q + XLEN'(4);

    sc_wordmem #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
        .clk   (clk),
        .we    (imem_ld_en),
        .widx  (imem_ld_idx),
        .wdata (imem_ld_word),
        .ridx  (pc_q[IAW+1:2]),
        .rdata (instr)
    );

    sc_decode u_dec (
        .op_i  (instr[31:26]),
        .fn_i  (instr[5:0]),
        .rt_i  (instr[20:16]),
        .rd_i  (instr[15:11]),
        .ctl_o (ctl)
    );

    sc_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wb_en_o),
        .wa   (ctl.dst),
        .wd   (wb_val_o),
        .ra_a (instr[25:21]),
        .rd_a (rs_v),
        .ra_b (instr[20:16]),
        .rd_b (rt_v)
    );

    assign imm_ext = ctl.zext ? {{(XLEN-IMMW){1'b0}}, instr[IMMW-1:0]}
                              : {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
    assign alu_b   = ctl.b_imm ? imm_ext : rt_v;

    sc_alu u_alu (
        .a     (rs_v),
        .b     (alu_b),
        .shamt (instr[10:6]),
        .op    (ctl.alu),
        .y     (alu_y)
    );

    // load port has priority over a core store in the same cycle
    assign dm_we    = dmem_ld_en | st_en_o;
    assign dm_widx  = dmem_ld_en ? dmem_ld_idx : alu_y[DAW+1:2];
    assign dm_wdata = dmem_ld_en ? dmem_ld_word : rt_v;

    sc_wordmem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .widx  (dm_widx),
        .wdata (dm_wdata),
        .ridx  (alu_y[DAW+1:2]),
        .rdata (ld_v)
    );

    assign br_tgt  = pc_inc + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_tgt = {pc_inc[XLEN-1:XLEN-4], instr[25:0], 2'b00};
    assign reg_tgt = {rs_v[XLEN-1:2], 2'b00};

    // Purpose: choose the address of the next instruction.
    always_comb begin
        case (ctl.nxt)
            NX_EQ:   pc_nx = (rs_v == rt_v) ? br_tgt : pc_inc;
            NX_NE:   pc_nx = (rs_v != rt_v) ? br_tgt : pc_inc;
            NX_ABS:  pc_nx = jmp_tgt;
            NX_REG:  pc_nx = reg_tgt;
            default: pc_nx = pc_inc;
        endcase
    end

    assign pc_o      = pc_q;
    assign instr_o   = instr;
    assign wb_en_o   = rst_n && ctl.wr && (ctl.dst != '0);
    assign wb_reg_o  = ctl.dst;
    assign wb_val_o  = ctl.link ? pc_inc : (ctl.ld ? ld_v : alu_y);
    assign st_en_o   = rst_n && ctl.st;
    assign st_addr_o = alu_y;
    assign st_val_o  = rt_v;
endmodule

// File: rtl/sc_core_chk.sv
// Checker: port-level properties of the single-cycle core. Assumes it is
// bound to sc_core and sees the trace outputs of the executing instruction.
module sc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  op_i,
    input logic [5:0]  fn_i,
    input logic [31:0] pc_i,
    input logic        wb_en_i,
    input logic [4:0]  wb_reg_i,
    input logic [31:0] wb_val_i,
    input logic        st_en_i
);
    logic is_flow;
    assign is_flow = (op_i == 6'd2) || (op_i == 6'd3) || (op_i == 6'd4) ||
                     (op_i == 6'd5) || (op_i == 6'd0 && fn_i == 6'd8);

    // R1: a reset edge leaves the PC at zero
    p_pc_clear_r1: assert property (@(posedge clk) !rst_n |=> pc_i == 32'd0);

    // R1: nothing is written while reset is held
    p_quiet_reset_r1: assert property (@(posedge clk) !rst_n |-> (!wb_en_i && !st_en_i));

    // R12: every non-flow instruction advances the PC by exactly 4
    p_seq_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !is_flow |=> pc_i == $past(pc_i) + 32'd4);

    // R10: the PC stays word aligned
    p_pc_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_i[1:0] == 2'b00);

    // R11: register 0 is never reported as written
    p_zero_reg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_i |-> wb_reg_i != 5'd0);

    // R9: jump-and-link writes the return address to register 31
    p_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 6'd3 |-> (wb_en_i && wb_reg_i == 5'd31 && wb_val_i == pc_i + 32'd4));

    // R5: upper-immediate load leaves the low half clear
    p_hi_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 6'd15 && wb_en_i) |-> wb_val_i[15:0] == 16'h0000);

    // R7: a store writes memory and no register
    p_store_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 6'd43 |-> (st_en_i && !wb_en_i));
endmodule

bind sc_core sc_core_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (instr_o[31:26]),
    .fn_i     (instr_o[5:0]),
    .pc_i     (pc_o),
    .wb_en_i  (wb_en_o),
    .wb_reg_i (wb_reg_o),
    .wb_val_i (wb_val_o),
    .st_en_i  (st_en_o)
);

// File: tb/test_sc_core.sv
// Bench: directed program with hand-computed results, then random programs
// compared cycle by cycle against an instruction-level model.
module test_sc_core;
    localparam int CLK_PERIOD = 10;
    localparam int IMEM_WORDS = 512;
    localparam int DMEM_WORDS = 256;
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);
    localparam int RUN_CYCLES = 1500;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            imem_ld_en = 1'b0;
    logic [IAW-1:0]  imem_ld_idx = '0;
    logic [31:0]     imem_ld_word = '0;
    logic            dmem_ld_en = 1'b0;
    logic [DAW-1:0]  dmem_ld_idx = '0;
    logic [31:0]     dmem_ld_word = '0;
    logic [31:0]     pc_o, instr_o, wb_val_o, st_addr_o, st_val_o;
    logic            wb_en_o, st_en_o;
    logic [4:0]      wb_reg_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_imem [IMEM_WORDS];
    logic [31:0] m_dmem [DMEM_WORDS];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) i_sc_core (
        .clk(clk), .rst_n(rst_n),
        .imem_ld_en(imem_ld_en), .imem_ld_idx(imem_ld_idx), .imem_ld_word(imem_ld_word),
        .dmem_ld_en(dmem_ld_en), .dmem_ld_idx(dmem_ld_idx), .dmem_ld_word(dmem_ld_word),
        .pc_o(pc_o), .instr_o(instr_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o),
        .wb_val_o(wb_val_o), .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_val_o(st_val_o)
    );

    function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt,
                                          logic [4:0] rd, logic [4:0] sh);
        return {6'd0, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                          logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] field);
        return {op, field};
    endfunction

    function automatic logic [31:0] gen_instr();
        logic [5:0]  fns [9] = '{6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37, 6'd39, 6'd42, 6'd43};
        logic [5:0]  iops [7] = '{6'd8, 6'd9, 6'd10, 6'd11, 6'd12, 6'd13, 6'd15};
        logic [5:0]  uops [6] = '{6'd1, 6'd6, 6'd7, 6'd14, 6'd20, 6'd63};
        logic [4:0]  rs = 5'($urandom % 32);
        logic [4:0]  rt = 5'($urandom % 32);
        logic [4:0]  rd = 5'($urandom % 32);
        logic [15:0] imm = 16'($urandom);
        logic [15:0] off = 16'(int'($urandom % 13) - 6);
        case ($urandom % 16)
            0, 1:    return enc_r(fns[$urandom % 9], rs, rt, rd, 5'd0);
            2:       return enc_r(($urandom % 2) ? 6'd2 : 6'd0, 5'd0, rt, rd, 5'($urandom));
            3, 4:    return enc_i(iops[$urandom % 7], rs, rt, imm);
            5:       return enc_i(6'd35, rs, rt, imm);
            6:       return enc_i(6'd43, rs, rt, imm);
            7:       return enc_i(6'd4, rs, rt, off);
            8:       return enc_i(6'd5, rs, rt, off);
            9:       return enc_j(6'd2, 26'($urandom % IMEM_WORDS));
            10:      return enc_j(6'd3, 26'($urandom % IMEM_WORDS));
            11:      return enc_r(6'd8, rs, 5'd0, 5'd0, 5'd0);
            12:      return enc_i(uops[$urandom % 6], rs, rt, imm);
            13:      return enc_r(6'd1, rs, rt, rd, 5'd0);
            default: return 32'($urandom);
        endcase
    endfunction

    task automatic load_word(int idx, logic [31:0] iw, logic [31:0] dw);
        @(negedge clk);
        imem_ld_en = 1'b1; imem_ld_idx = IAW'(idx); imem_ld_word = iw;
        dmem_ld_en = (idx < DMEM_WORDS); dmem_ld_idx = DAW'(idx); dmem_ld_word = dw;
    endtask

    task automatic finish_load();
        @(negedge clk);
        imem_ld_en = 1'b0;
        dmem_ld_en = 1'b0;
    endtask

    // Checks the trace of one cycle with hand-computed values, then advances.
    task automatic chk(string tag, logic [31:0] e_pc, logic e_wen, logic [4:0] e_reg,
                       logic [31:0] e_val);
        n_chk++;
        if (pc_o !== e_pc || wb_en_o !== e_wen || (e_wen && (wb_reg_o !== e_reg || wb_val_o !== e_val))) begin
            n_fail++;
            $display("FAIL %s: pc=%h wen=%b reg=%0d val=%h expected pc=%h wen=%b reg=%0d val=%h",
                     tag, pc_o, wb_en_o, wb_reg_o, wb_val_o, e_pc, e_wen, e_reg, e_val);
        end
        @(negedge clk); #1;
    endtask

    function automatic string tag_of(logic [31:0] ins);
        logic [5:0] op = ins[31:26];
        logic [5:0] fn = ins[5:0];
        if (op == 6'd0) begin
            case (fn)
                6'd0, 6'd2:   return "R3";
                6'd42, 6'd43: return "R6";
                6'd8:         return "R10";
                6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37, 6'd39: return "R2";
                default:      return "R12";
            endcase
        end
        case (op)
            6'd2, 6'd3:               return "R9";
            6'd4, 6'd5:               return "R8";
            6'd8, 6'd9, 6'd12, 6'd13: return "R4";
            6'd10, 6'd11:             return "R6";
            6'd15:                    return "R5";
            6'd35, 6'd43:             return "R7";
            default:                  return "R12";
        endcase
    endfunction

    // Model one instruction, compare the trace, then commit the model state.
    task automatic model_step();
        logic [31:0] ins = m_imem[m_pc[IAW+1:2]];
        logic [5:0]  op = ins[31:26];
        logic [5:0]  fn = ins[5:0];
        logic [4:0]  sh = ins[10:6];
        logic [31:0] a = m_rf[ins[25:21]];
        logic [31:0] b = m_rf[ins[20:16]];
        logic [31:0] se = {{16{ins[15]}}, ins[15:0]};
        logic [31:0] ze = {16'h0, ins[15:0]};
        logic [31:0] nxt = m_pc + 32'd4;
        logic [31:0] inc = m_pc + 32'd4;
        logic [31:0] val = '0;
        logic [31:0] addr = a + se;
        logic [4:0]  dst = '0;
        logic        wr = 1'b0;
        logic        sen = 1'b0;
        logic        wen;
        logic        ok;
        string       tag = tag_of(ins);
        case (op)
            6'd0: begin
                dst = ins[15:11]; wr = 1'b1;
                case (fn)
                    6'd32, 6'd33: val = a + b;
                    6'd34, 6'd35: val = a - b;
                    6'd36:        val = a & b;
                    6'd37:        val = a | b;
                    6'd39:        val = ~(a | b);
                    6'd42:        val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    6'd43:        val = (a < b) ? 32'd1 : 32'd0;
                    6'd0:         val = b << sh;
                    6'd2:         val = b >> sh;
                    6'd8: begin wr = 1'b0; nxt = {a[31:2], 2'b00}; end
                    default:      wr = 1'b0;
                endcase
            end
            6'd2: nxt = {inc[31:28], ins[25:0], 2'b00};
            6'd3: begin nxt = {inc[31:28], ins[25:0], 2'b00}; wr = 1'b1; dst = 5'd31; val = inc; end
            6'd4: if (a == b) nxt = inc + {se[29:0], 2'b00};
            6'd5: if (a != b) nxt = inc + {se[29:0], 2'b00};
            6'd8, 6'd9: begin wr = 1'b1; dst = ins[20:16]; val = a + se; end
            6'd10: begin wr = 1'b1; dst = ins[20:16]; val = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0; end
            6'd11: begin wr = 1'b1; dst = ins[20:16]; val = (a < se) ? 32'd1 : 32'd0; end
            6'd12: begin wr = 1'b1; dst = ins[20:16]; val = a & ze; end
            6'd13: begin wr = 1'b1; dst = ins[20:16]; val = a | ze; end
            6'd15: begin wr = 1'b1; dst = ins[20:16]; val = {ins[15:0], 16'h0}; end
            6'd35: begin wr = 1'b1; dst = ins[20:16]; val = m_dmem[addr[DAW+1:2]]; end
            6'd43: sen = 1'b1;
            default: ;
        endcase
        wen = wr && (dst != 5'd0);
        if (wr && dst == 5'd0) tag = {tag, "/R11"};
        ok = (pc_o === m_pc) && (instr_o === ins) && (wb_en_o === wen) &&
             (!wen || (wb_reg_o === dst && wb_val_o === val)) && (st_en_o === sen) &&
             (!sen || (st_addr_o === addr && st_val_o === b));
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: pc=%h ins=%h wb=%b/%0d/%h st=%b/%h/%h expected pc=%h ins=%h wb=%b/%0d/%h st=%b/%h/%h",
                     tag, pc_o, instr_o, wb_en_o, wb_reg_o, wb_val_o, st_en_o, st_addr_o, st_val_o,
                     m_pc, ins, wen, dst, val, sen, addr, b);
        end
        if (wen) m_rf[dst] = val;
        if (sen) m_dmem[addr[DAW+1:2]] = b;
        m_pc = nxt;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed program
        for (int i = 0; i < IMEM_WORDS; i++) m_imem[i] = '0;
        m_imem[0]   = enc_i(6'd15, 5'd0, 5'd1, 16'h8000);
        m_imem[1]   = enc_i(6'd13, 5'd1, 5'd1, 16'h0001);
        m_imem[2]   = enc_i(6'd8, 5'd0, 5'd2, 16'hFFFF);
        m_imem[3]   = enc_r(6'd42, 5'd1, 5'd0, 5'd3, 5'd0);
        m_imem[4]   = enc_r(6'd43, 5'd1, 5'd0, 5'd4, 5'd0);
        m_imem[5]   = enc_r(6'd0, 5'd0, 5'd2, 5'd6, 5'd4);
        m_imem[6]   = enc_r(6'd2, 5'd0, 5'd2, 5'd7, 5'd28);
        m_imem[7]   = enc_i(6'd43, 5'd0, 5'd1, 16'd8);
        m_imem[8]   = enc_i(6'd35, 5'd0, 5'd8, 16'd8);
        m_imem[9]   = enc_i(6'd8, 5'd0, 5'd0, 16'd5);
        m_imem[10]  = enc_i(6'd12, 5'd2, 5'd9, 16'hFFFF);
        m_imem[11]  = 32'hFC00_0000;
        m_imem[12]  = enc_j(6'd3, 26'd251);
        m_imem[13]  = enc_i(6'd5, 5'd1, 5'd1, 16'hFFFF);
        m_imem[14]  = enc_j(6'd2, 26'd14);
        m_imem[251] = enc_i(6'd4, 5'd0, 5'd0, 16'd5);
        m_imem[257] = enc_r(6'd8, 5'd31, 5'd0, 5'd0, 5'd0);
        for (int i = 0; i < IMEM_WORDS; i++) load_word(i, m_imem[i], 32'd0);
        finish_load();
        #1;
        n_chk++;
        if (pc_o !== 32'd0 || wb_en_o !== 1'b0 || st_en_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: pc=%h wen=%b sen=%b expected pc=0 wen=0 sen=0", pc_o, wb_en_o, st_en_o);
        end
        n_chk++;
        if (instr_o !== m_imem[0]) begin
            n_fail++;
            $display("FAIL R13: instr=%h expected %h", instr_o, m_imem[0]);
        end
        rst_n = 1'b1; #1;
        chk("R5", 32'd0, 1'b1, 5'd1, 32'h8000_0000);
        chk("R4", 32'd4, 1'b1, 5'd1, 32'h8000_0001);
        chk("R4", 32'd8, 1'b1, 5'd2, 32'hFFFF_FFFF);
        chk("R6", 32'd12, 1'b1, 5'd3, 32'd1);
        chk("R6", 32'd16, 1'b1, 5'd4, 32'd0);
        chk("R3", 32'd20, 1'b1, 5'd6, 32'hFFFF_FFF0);
        chk("R3", 32'd24, 1'b1, 5'd7, 32'h0000_000F);
        n_chk++;
        if (st_en_o !== 1'b1 || st_addr_o !== 32'd8 || st_val_o !== 32'h8000_0001) begin
            n_fail++;
            $display("FAIL R7: st=%b/%h/%h expected 1/00000008/80000001", st_en_o, st_addr_o, st_val_o);
        end
        chk("R7", 32'd28, 1'b0, 5'd0, 32'd0);
        chk("R7", 32'd32, 1'b1, 5'd8, 32'h8000_0001);
        chk("R11", 32'd36, 1'b0, 5'd0, 32'd0);
        chk("R4", 32'd40, 1'b1, 5'd9, 32'h0000_FFFF);
        chk("R12", 32'd44, 1'b0, 5'd0, 32'd0);
        chk("R9", 32'd48, 1'b1, 5'd31, 32'd52);
        chk("R8", 32'd1004, 1'b0, 5'd0, 32'd0);
        chk("R10", 32'd1028, 1'b0, 5'd0, 32'd0);
        chk("R8", 32'd52, 1'b0, 5'd0, 32'd0);
        chk("R9", 32'd56, 1'b0, 5'd0, 32'd0);
        chk("R9", 32'd56, 1'b0, 5'd0, 32'd0);

        // random programs against the model
        for (int ph = 0; ph < 3; ph++) begin
            rst_n = 1'b0; #1;
            n_chk++;
            if (wb_en_o !== 1'b0 || st_en_o !== 1'b0) begin
                n_fail++;
                $display("FAIL R1: wen=%b sen=%b in reset expected 0/0", wb_en_o, st_en_o);
            end
            for (int i = 0; i < IMEM_WORDS; i++) begin
                m_imem[i] = gen_instr();
                if (i < DMEM_WORDS) m_dmem[i] = 32'($urandom);
                load_word(i, m_imem[i], (i < DMEM_WORDS) ? m_dmem[i] : 32'd0);
            end
            finish_load();
            #1;
            n_chk++;
            if (pc_o !== 32'd0) begin
                n_fail++;
                $display("FAIL R1: pc=%h after reset expected 00000000", pc_o);
            end
            for (int r = 0; r < 32; r++) m_rf[r] = '0;
            m_pc = '0;
            rst_n = 1'b1; #1;
            for (int c = 0; c < RUN_CYCLES; c++) begin
                model_step();
                @(negedge clk); #1;
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule